// File: doc/BRIEF.md
# Octal-Field Register Move and Accumulator ALU Unit

This unit carries out the two regular classes of an 8-bit opcode set whose bits split 2-3-3, as an octal reading of the byte shows. It owns eight general registers. Register 7 is the accumulator, so the file can serve as a shallow pseudo-stack in which any entry can meet the accumulator. One opcode is accepted on each clock in which its valid strobe is high. Register writes and flag updates become visible on the next cycle, together with a completion pulse.

Opcodes of the two irregular classes, top bits 00 and 11, are not executed. They leave every register and flag as it was and raise an unimplemented indication instead. Results from logic outside this unit, such as immediate loads and memory reads, enter through a single external write port. An opcode on the same clock always takes precedence over that port. A combinational read port shows any register.

Top module: `oct_alu_unit`

## Requirements
- R1: After reset, all eight registers, all four flags, `done_o` and `unimpl_o` read zero.
- R2: Opcode bits [7:6] select the class, bits [5:3] form the middle field and bits [2:0] the low field. Register index 7 is the accumulator.
- R3: Class 01 copies the register named by the low field into the register named by the middle field. Flags are left unchanged.
- R4: Class 10 with middle field 0 (ADD) or 1 (ADC) writes A+S or A+S+carry to the accumulator, where S is the register named by the low field. Carry is set to the carry-out of bit 7.
- R5: Class 10 with middle field 2 (SUB) or 3 (SBC) writes A−S or A−S−carry to the accumulator. Carry is set when a borrow occurs, that is, when the true difference is negative.
- R6: Class 10 with middle field 4 (AND), 5 (XOR) or 6 (OR) writes the bitwise result to the accumulator and clears carry.
- R7: Class 10 with middle field 7 (CMP) sets the flags exactly as SUB would, but leaves the accumulator unchanged.
- R8: `flags_o` bit 0 is carry, bit 1 is zero (result equals 0), bit 2 is sign (result bit 7) and bit 3 is parity (1 when the result has an even number of one bits). All four flags are updated by every class 10 opcode.
- R9: A valid opcode of class 00 or 11 drives `unimpl_o` high on the next cycle, keeps `done_o` low, and changes no register or flag.
- R10: `done_o` is high for exactly the one cycle after each valid class 01 or 10 opcode. Cycles without a valid opcode or external write change nothing.
- R11: `rd_data_o` shows the register selected by `rd_sel_i` combinationally.
- R12: The external write port loads `ext_data_i` into register `ext_sel_i` on the next edge, but only when `op_valid_i` is low. When `op_valid_i` is high the external write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode strobe |
| op_code_i | input | 8 | Opcode, fields 2-3-3 |
| ext_we_i | input | 1 | External register write enable |
| ext_sel_i | input | 3 | External write register index |
| ext_data_i | input | DATA_W | External write data |
| rd_sel_i | input | 3 | Read port register index |
| done_o | output | 1 | Completion pulse for an executed opcode |
| unimpl_o | output | 1 | Pulse for a class 00/11 opcode |
| flags_o | output | 4 | {parity, sign, zero, carry} |
| acc_o | output | DATA_W | Accumulator (register 7) |
| rd_data_o | output | DATA_W | Selected register contents |

## Verification
An opcode driven before edge N shows its register, accumulator, flag, `done_o` and `unimpl_o` effects after edge N. Those effects last until the next edge, and `done_o` and `unimpl_o` fall one edge later. The bench drives the opcode just after a falling edge, removes it at the next falling edge, and samples all registered outputs shortly after that. The read port is combinational. The bench reads it one register per cycle in the idle cycles that follow, which also confirms that the completion pulse has dropped and that idle cycles disturb nothing. An external write is likewise visible after the one edge that captures it.

// File: rtl/oct_pkg.sv
package oct_pkg;

    localparam int REG_N   = 8;
    localparam int IDX_W   = 3;
    localparam int ACC_IDX = 7;

    typedef enum logic [1:0] {
        GRP_MISC = 2'b00,
        GRP_MOVE = 2'b01,
        GRP_ALU  = 2'b10,
        GRP_FLOW = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_ADC = 3'd1,
        ALU_SUB = 3'd2,
        ALU_SBC = 3'd3,
        ALU_AND = 3'd4,
        ALU_XOR = 3'd5,
        ALU_OR  = 3'd6,
        ALU_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic par;
        logic sgn;
        logic zro;
        logic cry;
    } flags_t;

    typedef struct packed {
        logic             is_move;
        logic             is_alu;
        logic             is_unimpl;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
        alu_op_e          op;
    } dec_t;

    typedef struct packed {
        flags_t flags;
        logic   done;
        logic   unimpl;
    } ctl_t;

endpackage

// File: rtl/oct_decode.sv
module oct_decode
    import oct_pkg::*;
(
    input  logic       valid_i,
    input  logic [7:0] code_i,
    output dec_t       dec_o
);

    grp_e grp;

    always_comb begin
        grp             = grp_e'(code_i[7:6]);
        dec_o.dst       = code_i[5:3];
        dec_o.src       = code_i[2:0];
        dec_o.op        = alu_op_e'(code_i[5:3]);
        dec_o.is_move   = valid_i && (grp == GRP_MOVE);
        dec_o.is_alu    = valid_i && (grp == GRP_ALU);
        dec_o.is_unimpl = valid_i && ((grp == GRP_MISC) || (grp == GRP_FLOW));
    end

endmodule

// File: rtl/oct_alu.sv
module oct_alu
    import oct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output flags_t            flags_o,
    output logic              wr_acc_o
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] a_x;
    logic [EXT_W-1:0] b_x;
    logic [EXT_W-1:0] c_x;
    logic [EXT_W-1:0] wide;

    always_comb begin
        a_x = {1'b0, a_i};
        b_x = {1'b0, b_i};
        c_x = {{DATA_W{1'b0}}, cin_i};
        unique case (op_i)
            ALU_ADD: wide = a_x + b_x;
            ALU_ADC: wide = a_x + b_x + c_x;
            ALU_SUB: wide = a_x - b_x;
            ALU_SBC: wide = a_x - b_x - c_x;
            ALU_AND: wide = {1'b0, a_i & b_i};
            ALU_XOR: wide = {1'b0, a_i ^ b_i};
            ALU_OR:  wide = {1'b0, a_i | b_i};
            default: wide = a_x - b_x;
        endcase
        res_o         = wide[DATA_W-1:0];
        flags_o.cry   = wide[DATA_W];
        flags_o.zro   = (wide[DATA_W-1:0] == '0);
        flags_o.sgn   = wide[DATA_W-1];
        flags_o.par   = ~^wide[DATA_W-1:0];
        wr_acc_o      = (op_i != ALU_CMP);
    end

endmodule

// File: rtl/oct_regfile.sv
module oct_regfile #(
    parameter int DATA_W  = 8,
    parameter int REG_N   = 8,
    parameter int ACC_IDX = 7,
    localparam int IDX_W  = $clog2(REG_N)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wa_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [IDX_W-1:0]  ra_i,
    input  logic [IDX_W-1:0]  rb_i,
    output logic [DATA_W-1:0] ra_data_o,
    output logic [DATA_W-1:0] rb_data_o,
    output logic [DATA_W-1:0] acc_o
);

    logic [DATA_W-1:0] regs_d [REG_N];
    logic [DATA_W-1:0] regs_q [REG_N];

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (we_i && (wa_i == IDX_W'(g))) begin
                regs_d[g] = wd_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        ra_data_o = regs_q[ra_i];
        rb_data_o = regs_q[rb_i];
        acc_o     = regs_q[ACC_IDX];
    end

endmodule

// File: rtl/oct_alu_unit.sv
module oct_alu_unit
    import oct_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              op_valid_i,
    input  logic [7:0]        op_code_i,
    input  logic              ext_we_i,
    input  logic [2:0]        ext_sel_i,
    input  logic [DATA_W-1:0] ext_data_i,
    input  logic [2:0]        rd_sel_i,
    output logic              done_o,
    output logic              unimpl_o,
    output logic [3:0]        flags_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] rd_data_o
);

    dec_t              dec;
    ctl_t              ctl_d;
    ctl_t              ctl_q;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_wa;
    logic [DATA_W-1:0] rf_wd;
    logic [DATA_W-1:0] src_data;
    logic [DATA_W-1:0] acc_data;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;
    logic              alu_wr_acc;

    oct_decode u_dec (
        .valid_i (op_valid_i),
        .code_i  (op_code_i),
        .dec_o   (dec)
    );

    oct_regfile #(
        .DATA_W  (DATA_W),
        .REG_N   (REG_N),
        .ACC_IDX (ACC_IDX)
    ) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (rf_we),
        .wa_i      (rf_wa),
        .wd_i      (rf_wd),
        .ra_i      (dec.src),
        .rb_i      (rd_sel_i),
        .ra_data_o (src_data),
        .rb_data_o (rd_data_o),
        .acc_o     (acc_data)
    );

    oct_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a_i      (acc_data),
        .b_i      (src_data),
        .cin_i    (ctl_q.flags.cry),
        .op_i     (dec.op),
        .res_o    (alu_res),
        .flags_o  (alu_flags),
        .wr_acc_o (alu_wr_acc)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.unimpl = 1'b0;
        rf_we        = 1'b0;
        rf_wa        = ext_sel_i;
        rf_wd        = ext_data_i;
        if (op_valid_i) begin
            if (dec.is_move) begin
                rf_we      = 1'b1;
                rf_wa      = dec.dst;
                rf_wd      = src_data;
                ctl_d.done = 1'b1;
            end else if (dec.is_alu) begin
                rf_we       = alu_wr_acc;
                rf_wa       = IDX_W'(ACC_IDX);
                rf_wd       = alu_res;
                ctl_d.flags = alu_flags;
                ctl_d.done  = 1'b1;
            end else if (dec.is_unimpl) begin
                ctl_d.unimpl = 1'b1;
            end
        end else if (ext_we_i) begin
            rf_we = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_o   = ctl_q.done;
    assign unimpl_o = ctl_q.unimpl;
    assign flags_o  = ctl_q.flags;
    assign acc_o    = acc_data;

endmodule

// File: rtl/oct_alu_unit_chk.sv
module oct_alu_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              op_valid_i,
    input logic [7:0]        op_code_i,
    input logic              ext_we_i,
    input logic [2:0]        ext_sel_i,
    input logic              done_o,
    input logic              unimpl_o,
    input logic [3:0]        flags_o,
    input logic [DATA_W-1:0] acc_o
);

    logic is_move;
    logic is_alu;
    logic is_odd;
    logic is_logic;
    logic is_cmp;

    always_comb begin
        is_move  = op_valid_i && (op_code_i[7:6] == 2'b01);
        is_alu   = op_valid_i && (op_code_i[7:6] == 2'b10);
        is_odd   = op_valid_i && (op_code_i[7:6] == 2'b00 || op_code_i[7:6] == 2'b11);
        is_logic = is_alu && (op_code_i[5:3] == 3'd4 || op_code_i[5:3] == 3'd5
                              || op_code_i[5:3] == 3'd6);
        is_cmp   = is_alu && (op_code_i[5:3] == 3'd7);
    end

    AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni) is_move |=> $stable(flags_o)); // R3
    AST_MOVE_SPARES_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni) is_move && op_code_i[5:3] != 3'd7 |=> $stable(acc_o)); // R3
    AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni) is_logic |=> !flags_o[0]); // R6
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni) is_cmp |=> $stable(acc_o)); // R7
    AST_ZERO_MATCHES_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni) is_alu && !is_cmp |=> flags_o[1] == (acc_o == '0)); // R8
    AST_PARITY_MATCHES_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni) is_alu && !is_cmp |=> flags_o[3] == ~^acc_o); // R8
    AST_UNIMPL_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni) is_odd |=> unimpl_o && !done_o && $stable(flags_o) && $stable(acc_o)); // R9
    AST_DONE_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni) (is_move || is_alu) |=> done_o); // R10
    AST_NO_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !op_valid_i |=> !done_o && !unimpl_o); // R10
    AST_EXT_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni) is_odd && ext_we_i && ext_sel_i == 3'd7 |=> $stable(acc_o)); // R12

endmodule

bind oct_alu_unit oct_alu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .ext_we_i   (ext_we_i),
    .ext_sel_i  (ext_sel_i),
    .done_o     (done_o),
    .unimpl_o   (unimpl_o),
    .flags_o    (flags_o),
    .acc_o      (acc_o)
);

// File: tb/oct_alu_unit_test.sv
module oct_alu_unit_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [7:0] op_code;
    logic       ext_we;
    logic [2:0] ext_sel;
    logic [7:0] ext_data;
    logic [2:0] rd_sel;
    logic       done;
    logic       unimpl;
    logic [3:0] flags;
    logic [7:0] acc;
    logic [7:0] rd_data;

    always #4 clk = ~clk;

    oct_alu_unit uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .op_valid_i (op_valid),
        .op_code_i  (op_code),
        .ext_we_i   (ext_we),
        .ext_sel_i  (ext_sel),
        .ext_data_i (ext_data),
        .rd_sel_i   (rd_sel),
        .done_o     (done),
        .unimpl_o   (unimpl),
        .flags_o    (flags),
        .acc_o      (acc),
        .rd_data_o  (rd_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  m_reg [8];
    logic [3:0]  m_flags;
    logic        m_done;
    logic        m_unimpl;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0] ^ lfsr[15:8];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op);
        if (op[7:6] == 2'b01) return "R3";
        if (op[7:6] == 2'b10) begin
            case (op[5:3])
                3'd0, 3'd1:       return "R4";
                3'd2, 3'd3:       return "R5";
                3'd4, 3'd5, 3'd6: return "R6";
                default:          return "R7";
            endcase
        end
        return "R9";
    endfunction

    task automatic model(input logic [7:0] op);
        int a, b, cin, t;
        logic [7:0] res;
        m_done   = 1'b0;
        m_unimpl = 1'b0;
        if (op[7:6] == 2'b01) begin
            m_reg[op[5:3]] = m_reg[op[2:0]];
            m_done = 1'b1;
        end else if (op[7:6] == 2'b10) begin
            a   = int'(m_reg[7]);
            b   = int'(m_reg[op[2:0]]);
            cin = int'(m_flags[0]);
            t   = 0;
            case (op[5:3])
                3'd0: t = a + b;
                3'd1: t = a + b + cin;
                3'd2: t = a - b;
                3'd3: t = a - b - cin;
                3'd4: t = a & b;
                3'd5: t = a ^ b;
                3'd6: t = a | b;
                default: t = a - b;
            endcase
            res = t[7:0];
            m_flags[0] = (t < 0) || (t > 255);
            m_flags[1] = (res == 8'h00);
            m_flags[2] = res[7];
            m_flags[3] = ($countones(res) % 2) == 0;
            if (op[5:3] != 3'd7) m_reg[7] = res;
            m_done = 1'b1;
        end else begin
            m_unimpl = 1'b1;
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_sel = 3'(i);
            #1;
            if (i == 0) begin
                chk("R10", "done idle", int'(done), 0);
                chk("R10", "unimpl idle", int'(unimpl), 0);
            end
            chk(tag, $sformatf("reg%0d", i), int'(rd_data), int'(m_reg[i]));
        end
    endtask

    task automatic write_all();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ext_we   = 1'b1;
            ext_sel  = 3'(i);
            ext_data = next_rand();
            m_reg[i] = ext_data;
        end
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic run_op(input logic [7:0] op);
        string t;
        t = tag_of(op);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        model(op);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R10", $sformatf("done op %0h", op), int'(done), int'(m_done));
        chk("R9", $sformatf("unimpl op %0h", op), int'(unimpl), int'(m_unimpl));
        chk((op[7:6] == 2'b10) ? "R8" : t, $sformatf("flags op %0h", op), int'(flags), int'(m_flags));
        chk(t, $sformatf("acc op %0h", op), int'(acc), int'(m_reg[7]));
        read_all({t, "/R2"});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        op_valid = 1'b0;
        op_code  = 8'h00;
        ext_we   = 1'b0;
        ext_sel  = 3'd0;
        ext_data = 8'h00;
        rd_sel   = 3'd0;
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_flags = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "done", int'(done), 0);
        chk("R1", "unimpl", int'(unimpl), 0);
        chk("R1", "flags", int'(flags), 0);
        chk("R1", "acc", int'(acc), 0);
        read_all("R1/R11");

        // R4 R5 carry paths: forced overflow, then carry-in consumed
        @(negedge clk); ext_we = 1'b1; ext_sel = 3'd7; ext_data = 8'hFF; m_reg[7] = 8'hFF;
        @(negedge clk); ext_sel = 3'd1; ext_data = 8'h01; m_reg[1] = 8'h01;
        @(negedge clk); ext_we = 1'b0;
        run_op(8'h81);   // ADD A,r1 -> 00, carry
        run_op(8'h89);   // ADC A,r1 -> 02
        run_op(8'h91);   // SUB A,r1 -> 01
        run_op(8'h91);   // SUB -> 00
        run_op(8'h91);   // SUB -> FF borrow
        run_op(8'h99);   // SBC uses borrow

        // R2 R3 R4 R5 R6 R7 R8 R9: full opcode sweep over random register contents
        for (int round = 0; round < 3; round++) begin
            for (int op = 0; op < 256; op++) begin
                write_all();
                run_op(8'(op));
            end
        end

        // R12: external write colliding with a valid opcode is dropped
        write_all();
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 8'h78;          // move r0 -> accumulator
        ext_we   = 1'b1;
        ext_sel  = 3'd1;
        ext_data = ~m_reg[1];
        model(8'h78);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 8'h3F;          // class 00 with external write to accumulator
        ext_sel  = 3'd7;
        ext_data = ~m_reg[7];
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        ext_we   = 1'b0;
        #1;
        chk("R12", "acc after collision", int'(acc), int'(m_reg[7]));
        read_all("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule